// File: doc/BRIEF.md
# Dual 8-bit Lane Processing Element with Split/Merge Accumulator

This block is a pair of 8-bit processing lanes that share one opcode. Each cycle with the enable high, every lane computes one 8-bit result and registers it together with a four-flag status word. An external sequencer reads the flags and branches on them. Besides ordinary add, subtract and bitwise operations, the lanes have signal-processing operations built in: add-compare-select for trellis decoding, absolute difference for motion search, a shift-weighted sum and a signed clamp.

A wide-mode input joins the lanes in two ways. The carry out of lane 0 feeds lane 1, so the pair forms a 16-bit adder. The two 8-bit running-sum registers then act as one 16-bit accumulator. In split mode each lane takes the external carry input and keeps its own 8-bit sum. The carry out of the top lane is a combinational output, so a neighbouring pair can extend the adder further.

Top module: `pe_pair`

## Requirements
- R1: While `rst` is high, at the next clock edge `res`, `flags`, `acs_sel`, `acc` and `acc_ovf` all become zero.
- R2: Opcode 0 (add) gives a+b+cin in each lane. Opcode 1 (subtract) gives a+~b+cin, so a plain subtraction needs cin=1. Flag C is the lane carry out. Flag V is signed overflow.
- R3: With `wide`=1, lane 1 takes its carry in from lane 0's carry out. With `wide`=0, both lanes take `carry_in`. `carry_out` is lane 1's carry out for the current inputs, without a register, and is 0 for opcodes other than 0 and 1.
- R4: Opcodes 2, 3 and 4 give a AND b, a OR b and a XOR b per lane.
- R5: Opcode 5 (add-compare-select) forms s1=a+b and s2=c+d modulo 256 and outputs the unsigned smaller one. The lane's `acs_sel` bit is 1 only when s2<s1, so a tie picks s1. For all other opcodes `acs_sel` is 0.
- R6: Opcode 7 gives (a<<c[1:0]) + (b<<d[1:0]) modulo 256.
- R7: Opcode 8 clamps signed a: below signed c it gives c, above signed d it gives d, otherwise a. The lower bound is tested first.
- R8: Opcode 6 gives |a-b| unsigned. With `wide`=0 each lane adds it to its own 8-bit accumulator modulo 256, and a wrap sets that lane's `acc_ovf` bit until it is cleared.
- R9: With `wide`=1, opcode 6 adds both lanes' differences into the 16-bit accumulator {acc[15:8],acc[7:0]} modulo 2^16. A sign change from non-negative to negative sets `acc_ovf[1]` until it is cleared. `acc_ovf[0]` is not touched.
- R10: `acc_clr` zeroes `acc` and `acc_ovf` at the next edge. It takes priority over accumulation and does not depend on `en`.
- R11: While `en` is low, `res`, `flags`, `acs_sel` and `acc` hold their values.
- R12: `flags[4i+3:4i]` of lane i = {N,V,Z,C}. N is result bit 7 and Z marks a zero result. C and V are 0 for opcodes other than 0 and 1. Unused opcodes 9 to 15 give result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Registers results and flags and allows accumulation |
| op | input | 4 | Opcode shared by both lanes |
| wide | input | 1 | Chains the carry and merges the accumulators |
| acc_clr | input | 1 | Synchronous accumulator clear |
| carry_in | input | 1 | Carry into lane 0, and into lane 1 in split mode |
| opnd_a | input | 16 | Operand a, lane i in bits [8i+7:8i] |
| opnd_b | input | 16 | Operand b |
| opnd_c | input | 16 | Operand c: second pair, shift amount or lower bound |
| opnd_d | input | 16 | Operand d: second pair, shift amount or upper bound |
| res | output | 16 | Registered lane results |
| flags | output | 8 | Registered {N,V,Z,C} per lane |
| acs_sel | output | 2 | Registered add-compare-select decision per lane |
| acc | output | 16 | Accumulator contents |
| acc_ovf | output | 2 | Sticky accumulator wrap or overflow bits |
| carry_out | output | 1 | Combinational carry out of lane 1 |

## Verification
A broken carry link shows up on `carry_out` in the same cycle. It shows up on lane 1's result and C flag one edge later. A wrong flag or result register differs from the model at the first edge after the faulty operation. A wrong accumulator is visible on `acc` at the edge after the first absolute-difference step. A missed overflow appears on `acc_ovf` only when the sum crosses the boundary, so the bench drives the merged sum past 0x7FFF and wraps a split lane past 0xFF on purpose.

// File: rtl/pe_pair_pkg.sv
package pe_pair_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_ACS  = 4'd5,
    OP_SAD  = 4'd6,
    OP_WSUM = 4'd7,
    OP_CLIP = 4'd8
  } pe_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } pe_flags_t;
endpackage

// File: rtl/pe_lane.sv
module pe_lane
  import pe_pair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     c,
  input  logic [W-1:0]     d,
  input  logic [OPC_W-1:0] op,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout,
  output logic             ovf,
  output logic             sel
);
  logic [W-1:0] bx, s1, s2, diff, wa, wb;
  logic [W:0]   sum;

  always_comb begin
    bx   = (op == OP_SUB) ? ~b : b;
    sum  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
    s1   = a + b;
    s2   = c + d;
    diff = (a >= b) ? (a - b) : (b - a);
    wa   = a << c[1:0];
    wb   = b << d[1:0];
    res  = '0;
    cout = 1'b0;
    ovf  = 1'b0;
    sel  = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        res  = sum[W-1:0];
        cout = sum[W];
        ovf  = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_ACS: begin
        sel = (s2 < s1);
        res = sel ? s2 : s1;
      end
      OP_SAD:  res = diff;
      OP_WSUM: res = wa + wb;
      OP_CLIP: begin
        if ($signed(a) < $signed(c))      res = c;
        else if ($signed(a) > $signed(d)) res = d;
        else                              res = a;
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/pe_acc.sv
module pe_acc #(
  parameter int W  = 8,
  parameter int NL = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           acc_en,
  input  logic           merged,
  input  logic [NL*W-1:0] addend,
  output logic [NL*W-1:0] acc,
  output logic [NL-1:0]   ovf
);
  localparam int AW = NL * W;

  logic [AW-1:0] split_next, wide_next, tot;
  logic [NL-1:0] split_c;
  logic          wide_ov;

  for (genvar i = 0; i < NL; i++) begin : g_seg
    assign {split_c[i], split_next[i*W +: W]} =
      {1'b0, acc[i*W +: W]} + {1'b0, addend[i*W +: W]};
  end

  always_comb begin
    tot = '0;
    for (int i = 0; i < NL; i++) tot = tot + AW'(addend[i*W +: W]);
    wide_next = acc + tot;
    wide_ov   = !acc[AW-1] && wide_next[AW-1];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      ovf <= '0;
    end else if (acc_en) begin
      if (merged) begin
        acc         <= wide_next;
        ovf[NL-1]   <= ovf[NL-1] | wide_ov;
      end else begin
        acc <= split_next;
        ovf <= ovf | split_c;
      end
    end
  end

  // R10
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0) && (ovf == '0));

  // R11
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !acc_en) |=> $stable(acc) && $stable(ovf));

  // R9
  merged_low_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && merged && !ovf[0]) |=> !ovf[0]);
endmodule

// File: rtl/pe_pair.sv
module pe_pair
  import pe_pair_pkg::*;
#(
  parameter int W  = 8,
  parameter int NL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [3:0]        op,
  input  logic              wide,
  input  logic              acc_clr,
  input  logic              carry_in,
  input  logic [NL*W-1:0]   opnd_a,
  input  logic [NL*W-1:0]   opnd_b,
  input  logic [NL*W-1:0]   opnd_c,
  input  logic [NL*W-1:0]   opnd_d,
  output logic [NL*W-1:0]   res,
  output logic [4*NL-1:0]   flags,
  output logic [NL-1:0]     acs_sel,
  output logic [NL*W-1:0]   acc,
  output logic [NL-1:0]     acc_ovf,
  output logic              carry_out
);
  logic [NL*W-1:0] lres;
  logic [NL-1:0]   lcin, lcout, lovf, lsel;
  pe_flags_t       lflag [NL];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign lcin[i] = carry_in;
    end else begin : g_link
      assign lcin[i] = wide ? lcout[i-1] : carry_in;
    end

    pe_lane #(.W(W)) u_lane (
      .a   (opnd_a[i*W +: W]),
      .b   (opnd_b[i*W +: W]),
      .c   (opnd_c[i*W +: W]),
      .d   (opnd_d[i*W +: W]),
      .op  (op),
      .cin (lcin[i]),
      .res (lres[i*W +: W]),
      .cout(lcout[i]),
      .ovf (lovf[i]),
      .sel (lsel[i])
    );

    always_comb begin
      lflag[i].n = lres[i*W + W-1];
      lflag[i].v = lovf[i];
      lflag[i].z = (lres[i*W +: W] == '0);
      lflag[i].c = lcout[i];
    end

    always_ff @(posedge clk) begin
      if (rst)     flags[4*i +: 4] <= '0;
      else if (en) flags[4*i +: 4] <= lflag[i];
    end
  end

  assign carry_out = lcout[NL-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      acs_sel <= '0;
    end else if (en) begin
      res     <= lres;
      acs_sel <= lsel;
    end
  end

  pe_acc #(.W(W), .NL(NL)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clr   (acc_clr),
    .acc_en(en && (op == OP_SAD)),
    .merged(wide),
    .addend(lres),
    .acc   (acc),
    .ovf   (acc_ovf)
  );

  // R11
  hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(res) && $stable(flags) && $stable(acs_sel));

  // R12
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (flags[1] == (res[W-1:0] == '0)));

  // R7
  clip_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_CLIP && $signed(opnd_c[W-1:0]) <= $signed(opnd_d[W-1:0]))
    |=> ($signed(res[W-1:0]) >= $signed($past(opnd_c[W-1:0]))) &&
        ($signed(res[W-1:0]) <= $signed($past(opnd_d[W-1:0]))));

  // R5
  acs_only_chk: assert property (@(posedge clk) disable iff (rst)
    (en && op != OP_ACS) |=> (acs_sel == '0));
endmodule

// File: tb/tb_pe_pair.sv
`timescale 1ns/1ps
module tb_pe_pair;
  logic        clk = 1'b0;
  logic        rst, en, wide, acc_clr, carry_in;
  logic [3:0]  op;
  logic [15:0] opnd_a, opnd_b, opnd_c, opnd_d;
  logic [15:0] res, acc;
  logic [7:0]  flags;
  logic [1:0]  acs_sel, acc_ovf;
  logic        carry_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_res[2];
  int m_flags, m_sel, m_acc, m_ovf;

  always #2 clk = ~clk;

  pe_pair dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .wide(wide), .acc_clr(acc_clr),
    .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .opnd_d(opnd_d), .res(res), .flags(flags), .acs_sel(acs_sel), .acc(acc),
    .acc_ovf(acc_ovf), .carry_out(carry_out)
  );

  function automatic int s8(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic string tag_for(int o);
    case (o)
      0, 1:    return "R2";
      2, 3, 4: return "R4";
      5:       return "R5";
      6:       return "R8";
      7:       return "R6";
      8:       return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // lane model: returns result, carry, overflow, select
  task automatic lane(int o, int a, int b, int c, int d, int cin,
                      output int r, output int co, output int v, output int sl);
    int bb, s, sv, s1, s2, sa, sc, sd;
    r = 0; co = 0; v = 0; sl = 0;
    case (o)
      0, 1: begin
        bb = (o == 1) ? 255 - b : b;
        s  = a + bb + cin;
        r  = s % 256; co = s / 256;
        sv = s8(a) + s8(bb) + cin;
        v  = (sv > 127 || sv < -128) ? 1 : 0;
      end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: begin
        s1 = (a + b) % 256; s2 = (c + d) % 256;
        sl = (s2 < s1) ? 1 : 0;
        r  = sl ? s2 : s1;
      end
      6: r = (a > b) ? a - b : b - a;
      7: r = (((a << (c % 4)) % 256) + ((b << (d % 4)) % 256)) % 256;
      8: begin
        sa = s8(a); sc = s8(c); sd = s8(d);
        if (sa < sc) r = c;
        else if (sa > sd) r = d;
        else r = a;
      end
      default: r = 0;
    endcase
  endtask

  task automatic step(int o, bit wd, bit clr, bit e, bit ci,
                      logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d);
    int r[2], co[2], v[2], sl[2], cin1, old, nw, lo, hi;
    string t;
    @(negedge clk);
    op = o[3:0]; wide = wd; acc_clr = clr; en = e; carry_in = ci;
    opnd_a = a; opnd_b = b; opnd_c = c; opnd_d = d;
    lane(o, a[7:0], b[7:0], c[7:0], d[7:0], ci, r[0], co[0], v[0], sl[0]);
    cin1 = wd ? co[0] : ci;
    lane(o, a[15:8], b[15:8], c[15:8], d[15:8], cin1, r[1], co[1], v[1], sl[1]);
    #1;
    check("R3", "carry_out", carry_out, co[1]);
    if (e) begin
      m_res[0] = r[0]; m_res[1] = r[1];
      m_sel = sl[0] | (sl[1] << 1);
      m_flags = 0;
      for (int i = 0; i < 2; i++)
        m_flags |= (((r[i] >> 7) << 3) | (v[i] << 2) | ((r[i] == 0) << 1) | co[i]) << (4*i);
    end
    if (clr) begin
      m_acc = 0; m_ovf = 0;
    end else if (e && o == 6) begin
      if (wd) begin
        old = m_acc; nw = (old + r[0] + r[1]) % 65536;
        if (old < 32768 && nw >= 32768) m_ovf |= 2;
        m_acc = nw;
      end else begin
        lo = (m_acc % 256) + r[0]; hi = (m_acc / 256) + r[1];
        if (lo > 255) m_ovf |= 1;
        if (hi > 255) m_ovf |= 2;
        m_acc = (hi % 256) * 256 + (lo % 256);
      end
    end
    @(posedge clk); #1;
    t = e ? tag_for(o) : "R11";
    check(t, "res", res, m_res[1] * 256 + m_res[0]);
    check(e ? "R12" : "R11", "flags", flags, m_flags);
    check(e ? "R5" : "R11", "acs_sel", acs_sel, m_sel);
    t = clr ? "R10" : (wd ? "R9" : "R8");
    check(t, "acc", acc, m_acc);
    check(t, "acc_ovf", acc_ovf, m_ovf);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 0; op = 0; wide = 0; acc_clr = 0; carry_in = 0;
    opnd_a = 16'h5A5A; opnd_b = 16'hA5A5; opnd_c = 0; opnd_d = 0;
    m_res[0] = 0; m_res[1] = 0; m_flags = 0; m_sel = 0; m_acc = 0; m_ovf = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "res", res, 0);
    check("R1", "flags", flags, 0);
    check("R1", "acs_sel", acs_sel, 0);
    check("R1", "acc", acc, 0);
    check("R1", "acc_ovf", acc_ovf, 0);
    @(negedge clk); rst = 0;

    // R2 add with signed overflow in lane 0
    step(0, 0, 0, 1, 0, 16'h107F, 16'h0101, 0, 0);
    // R3 chained 16-bit add, carry ripples into lane 1
    step(0, 1, 0, 1, 1, 16'h00FF, 16'h0000, 0, 0);
    // R3 chained carry out of the top lane
    step(0, 1, 0, 1, 0, 16'hFFFF, 16'h0001, 0, 0);
    // R2 chained subtract
    step(1, 1, 0, 1, 1, 16'h0100, 16'h0001, 0, 0);
    // R2 split subtract with borrow
    step(1, 0, 0, 1, 1, 16'h0305, 16'h0407, 0, 0);
    // R4 logic
    step(2, 0, 0, 1, 0, 16'hF0CC, 16'h3CAA, 0, 0);
    step(3, 0, 0, 1, 0, 16'hF0CC, 16'h3CAA, 0, 0);
    step(4, 0, 0, 1, 0, 16'hF0CC, 16'h3CAA, 0, 0);
    // R5 ACS: lane0 second pair wins, lane1 tie keeps first
    step(5, 0, 0, 1, 0, 16'h0203, 16'h0304, 16'h0302, 16'h0202);
    step(5, 0, 0, 1, 0, 16'h0109, 16'h0109, 16'h0201, 16'h0001);
    // R6 weighted sum
    step(7, 0, 0, 1, 0, 16'h4403, 16'h1105, 16'h0302, 16'h0001);
    // R7 clip below, above, inside
    step(8, 0, 0, 1, 0, 16'h7F80, 16'hxxxx, 16'hF0F0, 16'h2020);
    step(8, 0, 0, 1, 0, 16'h0505, 16'h0000, 16'hF0F0, 16'h2020);
    // R12 unused opcode gives zero
    step(11, 0, 0, 1, 0, 16'h1234, 16'h5678, 0, 0);
    // R8 split accumulate and wrap
    step(6, 0, 0, 1, 0, 16'h01FF, 16'h0300, 0, 0);
    step(6, 0, 0, 1, 0, 16'h01FF, 16'h0300, 0, 0);
    // R11 enable low holds everything
    step(0, 0, 0, 0, 0, 16'h1111, 16'h2222, 0, 0);
    step(6, 0, 0, 0, 0, 16'hFFFF, 16'h0000, 0, 0);
    // R10 clear with enable low
    step(6, 0, 1, 0, 0, 16'hFFFF, 16'h0000, 0, 0);
    // R9 merged accumulation beyond 0x7FFF
    for (int k = 0; k < 70; k++)
      step(6, 1, 0, 1, 0, 16'hFFFF, 16'h0000, 0, 0);
    // R10 clear beats accumulation
    step(6, 1, 1, 1, 0, 16'hFFFF, 16'h0000, 0, 0);

    for (int k = 0; k < 400; k++)
      step($urandom_range(0, 9), $urandom_range(0, 1), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 7) != 0), $urandom_range(0, 1),
           16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule